// File: doc/BRIEF.md
# Strap Latch and Startup Output Gate

This controller sits between a set of dual-purpose clock pins and the clock sources that feed them. After a power-on reset every pin floats, so board straps can set its level. On the first cycle the power-good input is seen high, the controller latches the strap levels once. It then drives every pin low for a startup interval of `START_CYC` cycles. After that interval each output may carry its source clock.

Four latched frequency straps can be read back in an 8-bit status byte. A fifth, the mode strap, sets the role of one pin. When the mode strap is 1, that pin is a reference clock output. When it is 0, that pin is released and its external level acts as an active-low power-down request. Per-output enable bits, a global release bit and the power-down request decide which outputs run. An output is opened or closed only while its source is low, so it never emits a shortened pulse.

States and transitions of the sequencer are as follows. `ST_SAMPLE` is entered on reset, and all pins float in it. `ST_SAMPLE` goes to `ST_HOLD` on the first cycle power-good is seen high, and the straps are captured on that same edge. `ST_HOLD` drives the pins low and goes to `ST_RUN` after `START_CYC` cycles. `ST_RUN` lets the gated clocks through and stays there until the next reset.

Top module: `strapgate_ctrl`

## Requirements
- R1: While reset is asserted and until power-good is first seen high, `clk_oe` and `clk_out` are all 0 and `strap_rd` reads 8'h87.
- R2: On the rising clock edge where the sequencer is sampling and `pwr_good` is 1, `strap_in[3:0]` is stored and appears at `strap_rd[6:3]`, and `strap_in[4]` is stored as the mode strap.
- R3: After the capture, changes on `strap_in` or `pwr_good` have no effect on `strap_rd` or on the sequence until the next reset.
- R4: For exactly `START_CYC` cycles after the capture, `clk_out` is all 0 and the pins are driven (`clk_oe` 1, subject to R8 and R9). The outputs may toggle only after that.
- R5: A gate opens or closes only at a clock edge where its `src_clk` bit is 0. While running, `clk_out[i]` equals `src_clk[i]` AND the gate, so an output rises or falls only together with its source.
- R6: `en_bits[i]` = 1 lets output i run and 0 stops it at logic 0.
- R7: With the mode strap at 0 and `pd_n` low, every output except index `FREE_IDX` (default 0) stops at 0. With the mode strap at 1, `pd_n` is ignored.
- R8: Output `REF_IDX` (default 1) is driven and may run only when the mode strap is 1. With the mode strap at 0, its `clk_oe` is 0.
- R9: `tri_all` = 1 sets every `clk_oe` bit to 0 in the same cycle, in any state.
- R10: `strap_rd` bits 7, 2, 1 and 0 always read 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| pwr_good | input | 1 | Supply-good indication that triggers the strap capture |
| strap_in | input | NFS+1 | Pin levels while floating: [3:0] frequency straps, [4] mode strap |
| pd_n | input | 1 | Power-down request, active low, used only when the mode strap is 0 |
| tri_all | input | 1 | Releases every pin to high impedance |
| en_bits | input | NOUT | Per-output run enable |
| src_clk | input | NOUT | Source clock of each output |
| clk_out | output | NOUT | Gated clock value of each pin |
| clk_oe | output | NOUT | Drive enable of each pin |
| strap_rd | output | 8 | Read-back byte: latched frequency straps in [6:3], other bits 1 |

## Verification
A sequencer stuck in the wrong state shows at the pins on the next edge. Stuck in sampling, the pins stay floating. Entering hold early or late moves the first toggle by one or more cycles against the reference model. A gate register that updates while its source is high shows as an output edge that the source does not have, and that appears within one source period. A corrupted strap register shows directly on `strap_rd` and on the drive state of the reference pin.

// File: rtl/strapgate_pkg.sv
package strapgate_pkg;

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_HOLD   = 2'd1,
        ST_RUN    = 2'd2
    } seq_state_e;

    localparam int RD_W   = 8;
    localparam int FS_LSB = 3;

endpackage

// File: rtl/strap_capture.sv
module strap_capture #(
    parameter int NFS = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           capture,
    input  logic [NFS:0]   pins,
    output logic [NFS-1:0] fs_q,
    output logic           mode_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q   <= '0;
            mode_q <= 1'b0;
        end else if (capture) begin
            fs_q   <= pins[NFS-1:0];
            mode_q <= pins[NFS];
        end
    end

endmodule

// File: rtl/start_seq.sv
module start_seq
    import strapgate_pkg::*;
#(
    parameter int START_CYC = 300000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_good,
    output seq_state_e state,
    output logic       capture,
    output logic       drive,
    output logic       run
);

    localparam int CW = $clog2(START_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(START_CYC - 1);

    seq_state_e    nxt;
    logic [CW-1:0] cnt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_SAMPLE: if (pwr_good)    nxt = ST_HOLD;
            ST_HOLD:   if (cnt == LAST) nxt = ST_RUN;
            ST_RUN:                     nxt = ST_RUN;
            default:                    nxt = ST_SAMPLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_SAMPLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                cnt <= '0;
        else if (state == ST_HOLD) cnt <= cnt + CW'(1);
        else                       cnt <= '0;
    end

    always_comb begin
        capture = 1'b0;
        drive   = 1'b0;
        run     = 1'b0;
        unique case (state)
            ST_SAMPLE: capture = pwr_good;
            ST_HOLD:   drive   = 1'b1;
            ST_RUN: begin
                drive = 1'b1;
                run   = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/clk_gate_cell.sv
module clk_gate_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic src,
    input  logic want,
    output logic out
);

    logic gate_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    gate_q <= 1'b0;
        else if (!run) gate_q <= 1'b0;
        else if (!src) gate_q <= want;
    end

    assign out = src & gate_q;

endmodule

// File: rtl/strapgate_ctrl.sv
module strapgate_ctrl
    import strapgate_pkg::*;
#(
    parameter int NOUT      = 6,
    parameter int NFS       = 4,
    parameter int START_CYC = 300000,
    parameter int FREE_IDX  = 0,
    parameter int REF_IDX   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_good,
    input  logic [NFS:0]      strap_in,
    input  logic              pd_n,
    input  logic              tri_all,
    input  logic [NOUT-1:0]   en_bits,
    input  logic [NOUT-1:0]   src_clk,
    output logic [NOUT-1:0]   clk_out,
    output logic [NOUT-1:0]   clk_oe,
    output logic [RD_W-1:0]   strap_rd
);

    seq_state_e     seq_state;
    logic           capture;
    logic           drive;
    logic           run;
    logic [NFS-1:0] fs_q;
    logic           mode_q;
    logic           pd_ok;

    start_seq #(.START_CYC(START_CYC)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_good (pwr_good),
        .state    (seq_state),
        .capture  (capture),
        .drive    (drive),
        .run      (run)
    );

    strap_capture #(.NFS(NFS)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .capture (capture),
        .pins    (strap_in),
        .fs_q    (fs_q),
        .mode_q  (mode_q)
    );

    assign pd_ok = mode_q | pd_n;

    for (genvar i = 0; i < NOUT; i++) begin : g_out
        logic want;
        logic pin_owned;
        if (i == REF_IDX) begin : g_ref
            assign pin_owned = mode_q;
        end else begin : g_plain
            assign pin_owned = 1'b1;
        end
        if (i == FREE_IDX) begin : g_free
            assign want = en_bits[i] & pin_owned;
        end else begin : g_stoppable
            assign want = en_bits[i] & pin_owned & pd_ok;
        end

        clk_gate_cell u_gate (
            .clk   (clk),
            .rst_n (rst_n),
            .run   (run),
            .src   (src_clk[i]),
            .want  (want),
            .out   (clk_out[i])
        );

        assign clk_oe[i] = drive & ~tri_all & pin_owned;
    end

    always_comb begin
        strap_rd = '1;
        strap_rd[FS_LSB +: NFS] = fs_q;
    end

endmodule

// File: rtl/strapgate_ctrl_chk.sv
module strapgate_ctrl_chk
    import strapgate_pkg::*;
#(
    parameter int NOUT = 6
) (
    input logic            clk,
    input logic            rst_n,
    input seq_state_e      state,
    input logic [NOUT-1:0] src_clk,
    input logic [NOUT-1:0] clk_out,
    input logic [NOUT-1:0] clk_oe,
    input logic [RD_W-1:0] strap_rd,
    input logic            tri_all
);

    AST_SAMPLE_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SAMPLE |-> clk_oe == '0); // R1

    AST_STRAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SAMPLE && $past(state) != ST_SAMPLE) |-> $stable(strap_rd)); // R3

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_HOLD |-> clk_out == '0); // R4

    AST_TRI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        tri_all |-> clk_oe == '0); // R9

    for (genvar i = 0; i < NOUT; i++) begin : g_edge
        AST_NO_RUNT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(clk_out[i]) |-> $rose(src_clk[i])); // R5
        AST_NO_RUNT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(clk_out[i]) |-> $fell(src_clk[i])); // R5
    end

endmodule

bind strapgate_ctrl strapgate_ctrl_chk #(.NOUT(NOUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .state    (seq_state),
    .src_clk  (src_clk),
    .clk_out  (clk_out),
    .clk_oe   (clk_oe),
    .strap_rd (strap_rd),
    .tri_all  (tri_all)
);

// File: tb/strapgate_ctrl_bench.sv
module strapgate_ctrl_bench;

    localparam int NOUT = 6;
    localparam int NFS  = 4;
    localparam int SC   = 16;
    localparam int FREE = 0;
    localparam int REFI = 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pwr_good = 1'b0;
    logic [NFS:0]    strap_in = '0;
    logic            pd_n = 1'b1;
    logic            tri_all = 1'b0;
    logic [NOUT-1:0] en_bits = '1;
    logic [NOUT-1:0] src_clk = '0;
    logic [NOUT-1:0] clk_out;
    logic [NOUT-1:0] clk_oe;
    logic [7:0]      strap_rd;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    strapgate_ctrl #(
        .NOUT(NOUT), .NFS(NFS), .START_CYC(SC), .FREE_IDX(FREE), .REF_IDX(REFI)
    ) u_strapgate_ctrl (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .strap_in(strap_in),
        .pd_n(pd_n), .tri_all(tri_all), .en_bits(en_bits), .src_clk(src_clk),
        .clk_out(clk_out), .clk_oe(clk_oe), .strap_rd(strap_rd)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // source clocks: output i toggles every i+1 falling edges
    initial begin
        int div [NOUT];
        for (int i = 0; i < NOUT; i++) div[i] = 0;
        forever begin
            @(negedge clk);
            for (int i = 0; i < NOUT; i++) begin
                div[i]++;
                if (div[i] > i) begin
                    div[i] = 0;
                    src_clk[i] = ~src_clk[i];
                end
            end
        end
    end

    // reference model
    int         m_st = 0;
    int         m_cnt = 0;
    logic [3:0] m_fs = '0;
    logic       m_mode = 1'b0;
    logic [NOUT-1:0] m_gate = '0;

    function automatic logic want_of(int i);
        logic w;
        w = en_bits[i];
        if (i == REFI && !m_mode) w = 1'b0;
        if (i != FREE && !m_mode && !pd_n) w = 1'b0;
        return w;
    endfunction

    always @(posedge clk) begin
        logic [NOUT-1:0] e_out;
        logic [NOUT-1:0] e_oe;
        logic [7:0]      e_rd;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_fs = '0; m_mode = 1'b0; m_gate = '0;
        end else begin
            for (int i = 0; i < NOUT; i++) begin
                if (m_st == 2) begin
                    if (!src_clk[i]) m_gate[i] = want_of(i);
                end else begin
                    m_gate[i] = 1'b0;
                end
            end
            case (m_st)
                0: if (pwr_good) begin
                    m_fs = strap_in[3:0]; m_mode = strap_in[4]; m_st = 1; m_cnt = 0;
                end
                1: begin
                    if (m_cnt == SC - 1) m_st = 2;
                    m_cnt++;
                end
                default: ;
            endcase
        end
        #2;
        for (int i = 0; i < NOUT; i++) begin
            e_out[i] = src_clk[i] & m_gate[i];
            e_oe[i]  = (m_st != 0) && !tri_all && !(i == REFI && !m_mode);
        end
        e_rd = 8'h87 | {1'b0, m_fs, 3'b000};
        chk(clk_out == e_out, "R5 clk_out", int'(clk_out), int'(e_out));
        chk(clk_oe == e_oe, "R4 clk_oe", int'(clk_oe), int'(e_oe));
        chk(strap_rd == e_rd, "R2 strap_rd", int'(strap_rd), int'(e_rd));
    end

    task automatic observe(input int n, output logic [NOUT-1:0] seen);
        seen = '0;
        repeat (n) begin
            @(posedge clk); #3;
            seen |= clk_out;
        end
    endtask

    initial begin
        logic [NOUT-1:0] seen;
        strap_in = 5'b1_0110;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        // R1: floating before power-good
        chk(clk_oe == '0 && clk_out == '0, "R1 float", int'(clk_oe), 0);
        chk(strap_rd == 8'h87, "R1 rd", int'(strap_rd), 8'h87);
        pwr_good = 1'b1;
        @(posedge clk); #3;
        chk(strap_rd == 8'hB7, "R2 latch", int'(strap_rd), 8'hB7);
        @(negedge clk);
        strap_in = 5'b0_1001;
        pwr_good = 1'b0;
        repeat (3) @(negedge clk);
        pwr_good = 1'b1;
        repeat (2) @(negedge clk);
        chk(strap_rd == 8'hB7, "R3 ignore", int'(strap_rd), 8'hB7);
        chk(clk_oe == 6'h3F && clk_out == '0, "R4 hold", int'(clk_out), 0);
        chk((strap_rd & 8'h87) == 8'h87, "R10 ones", int'(strap_rd), 8'h87);
        repeat (SC) @(negedge clk);
        observe(20, seen);
        chk(seen == 6'h3F, "R4 running", int'(seen), 6'h3F);
        @(negedge clk);
        en_bits = 6'b101010;
        repeat (12) @(negedge clk);
        observe(20, seen);
        chk(seen == 6'b101010, "R6 enables", int'(seen), 6'b101010);
        @(negedge clk);
        en_bits = '1;
        pd_n = 1'b0;
        repeat (12) @(negedge clk);
        observe(20, seen);
        chk(seen == 6'h3F, "R7 pd ignored", int'(seen), 6'h3F);
        chk(clk_oe[REFI] == 1'b1, "R8 ref driven", int'(clk_oe), 6'h3F);
        @(negedge clk);
        pd_n = 1'b1;
        tri_all = 1'b1;
        #3;
        chk(clk_oe == '0, "R9 release", int'(clk_oe), 0);
        repeat (5) @(negedge clk);
        tri_all = 1'b0;
        // second power-on with mode strap 0
        rst_n = 1'b0;
        pwr_good = 1'b0;
        repeat (2) @(negedge clk);
        chk(strap_rd == 8'h87 && clk_oe == '0, "R1 reset again", int'(strap_rd), 8'h87);
        rst_n = 1'b1;
        @(negedge clk);
        pwr_good = 1'b1;
        @(posedge clk); #3;
        chk(strap_rd == 8'hCF, "R2 relatch", int'(strap_rd), 8'hCF);
        repeat (SC + 2) @(negedge clk);
        chk(clk_oe == 6'b111101, "R8 ref released", int'(clk_oe), 6'b111101);
        observe(20, seen);
        chk(seen == 6'b111101, "R8 ref quiet", int'(seen), 6'b111101);
        @(negedge clk);
        pd_n = 1'b0;
        repeat (12) @(negedge clk);
        observe(20, seen);
        chk(seen == 6'b000001, "R7 power-down", int'(seen), 1);
        @(negedge clk);
        pd_n = 1'b1;
        repeat (12) @(negedge clk);
        observe(20, seen);
        chk(seen == 6'b111101, "R7 resume", int'(seen), 6'b111101);
        chk((strap_rd & 8'h87) == 8'h87, "R10 ones", int'(strap_rd), 8'h87);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule